// File: doc/BRIEF.md
# Asynchronous Bus Cycle Capture Unit

This block watches the pins of a 16-bit microprocessor with an asynchronous bus and turns each completed bus cycle into one record. A record holds a 24-bit byte address, the 16-bit data word and an 8-bit status byte. The pins are the CPU clock, an active-low address strobe, active-low upper and lower data strobes, read/write, the valid-memory-address line, three function code lines, the bus-grant-acknowledge line, address lines 23..1 and the data bus.

All pins are oversampled in one fast system clock domain. The CPU clock is a data signal here, and so is the address strobe. The processor releases the address strobe and both data strobes on the same falling CPU clock edge. For that reason the control and address lines go into a shadow register on every rising CPU clock edge. When the address strobe rises, the record is built from that shadow. The data bus is still valid at that moment, so it is taken directly at the strobe's rising edge.

Address bit 0 is not a pin. It is rebuilt from the shadowed upper data strobe level. A cycle in which neither data strobe was asserted is flagged as address-only.

Top module: `bus_cycle_capture`

## Requirements
- R1: For each completed bus cycle, `rec_valid` is high for exactly one system clock. With `SYNC_STAGES`=2, this is the third rising system clock edge after `as_n` rises. Between pulses, `rec_addr` and `rec_data` keep their last values.
- R2: `rec_status` packs the pin levels as follows. Bit 0 is `rd_wr`, bit 1 is `lds_n`, bit 2 is `uds_n` and bit 3 is `vma_n`. Bits 6..4 are `fc[2:0]` and bit 7 is `bgack_n`.
- R3: `rec_addr[23:1]` and `rec_status` come from the last rising `cpu_clk` edge seen before the `as_n` rise. A `cpu_clk` rise that is detected in the same system cycle as the `as_n` rise is not used. Pin changes that arrive together with the strobe rise are not recorded.
- R4: `rec_data` is the value on `data` at the rising edge of `as_n`. Earlier values are not used, even when they were present at the last CPU clock rise.
- R5: `rec_addr[0]` equals the shadowed `uds_n` level. 1 means an odd-byte access.
- R6: `rec_addr_only` is 1 exactly when both shadowed data strobes were high (not asserted).
- R7: While reset is held, all record outputs are 0. After reset, no record is produced until `as_n` has been seen falling. A strobe that is already low at reset release and then rises yields no record.
- R8: Toggling `cpu_clk` while `as_n` stays high produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_clk | input | 1 | CPU clock, sampled as data |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rd_wr | input | 1 | Read (1) / write (0) |
| vma_n | input | 1 | Valid memory address line |
| fc | input | 3 | Function codes |
| bgack_n | input | 1 | Bus grant acknowledge |
| addr_hi | input | ADDR_W-1 | Address lines ADDR_W-1..1 |
| data | input | DATA_W | Data bus |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_addr | output | ADDR_W | Byte address with rebuilt bit 0 |
| rec_data | output | DATA_W | Captured data word |
| rec_status | output | 8 | Packed status byte |
| rec_addr_only | output | 1 | Neither data strobe asserted |

## Verification
The shadow update on a CPU clock rise and the record commit on an address strobe rise can land in the same system cycle. The bench provokes this by raising `cpu_clk` and `as_n` on the same system clock. At that same moment it moves the address and releases the data strobes. The record is correct only if it shows the address and strobe levels from the previous CPU clock rise. New values, or strobes seen as released, count as a miscompare.

// File: rtl/bus_cycle_capture.sv
module bus_cycle_capture #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_clk,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rd_wr,
  input  logic              vma_n,
  input  logic [2:0]        fc,
  input  logic              bgack_n,
  input  logic [ADDR_W-1:1] addr_hi,
  input  logic [DATA_W-1:0] data,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data,
  output logic [7:0]        rec_status,
  output logic              rec_addr_only
);

  typedef struct packed {
    logic              cpu_clk;
    logic              as_n;
    logic [7:0]        stat;
    logic [ADDR_W-1:1] addr;
    logic [DATA_W-1:0] data;
  } pins_t;

  pins_t pin_now;
  pins_t pipe [SYNC_STAGES];
  pins_t cur;

  assign pin_now = '{cpu_clk: cpu_clk, as_n: as_n,
                     stat: {bgack_n, fc, vma_n, uds_n, lds_n, rd_wr},
                     addr: addr_hi, data: data};

  always_ff @(posedge clk) begin
    pipe[0] <= pin_now;
    for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
  end

  assign cur = pipe[SYNC_STAGES-1];

  logic cpu_prev, as_prev, in_cycle;
  logic cpu_rise, as_rise, as_fall;

  assign cpu_rise = cur.cpu_clk & ~cpu_prev;
  assign as_rise  = cur.as_n & ~as_prev;
  assign as_fall  = ~cur.as_n & as_prev;

  always_ff @(posedge clk) begin
    cpu_prev <= cur.cpu_clk;
    as_prev  <= cur.as_n;
  end

  logic [ADDR_W-1:1] sh_addr;
  logic [7:0]        sh_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_addr  <= '0;
      sh_stat  <= '0;
      in_cycle <= 1'b0;
    end else begin
      if (cpu_rise) begin
        sh_addr <= cur.addr;
        sh_stat <= cur.stat;
      end
      if (as_fall)      in_cycle <= 1'b1;
      else if (as_rise) in_cycle <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid     <= 1'b0;
      rec_addr      <= '0;
      rec_data      <= '0;
      rec_status    <= '0;
      rec_addr_only <= 1'b0;
    end else begin
      rec_valid <= as_rise & in_cycle;
      if (as_rise && in_cycle) begin
        rec_addr      <= {sh_addr, sh_stat[2]};
        rec_data      <= cur.data;
        rec_status    <= sh_stat;
        rec_addr_only <= sh_stat[2] & sh_stat[1];
      end
    end
  end

endmodule

// File: rtl/bus_cycle_capture_chk.sv
module bus_cycle_capture_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_n,
  input logic              rec_valid,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [DATA_W-1:0] rec_data,
  input logic [7:0]        rec_status,
  input logic              rec_addr_only
);

  logic low_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)         low_seen <= 1'b0;
    else if (!as_n)     low_seen <= 1'b1;
    else if (rec_valid) low_seen <= 1'b0;
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> ($stable(rec_addr) && $stable(rec_data)));

  p_addr_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_addr[0] == rec_status[2]));

  p_addr_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_addr_only == (rec_status[1] & rec_status[2])));

  p_needs_assert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> low_seen);

endmodule

bind bus_cycle_capture bus_cycle_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .rec_valid(rec_valid),
  .rec_addr(rec_addr), .rec_data(rec_data), .rec_status(rec_status),
  .rec_addr_only(rec_addr_only)
);

// File: tb/test_bus_cycle_capture.sv
module test_bus_cycle_capture;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_clk = 1'b0, as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic rd_wr = 1'b1, vma_n = 1'b1, bgack_n = 1'b1;
  logic [2:0] fc = '0;
  logic [23:1] addr_hi = '0;
  logic [15:0] data = '0;
  logic rec_valid, rec_addr_only;
  logic [23:0] rec_addr;
  logic [15:0] rec_data;
  logic [7:0] rec_status;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_cycle_capture i_bus_cycle_capture (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rd_wr(rd_wr), .vma_n(vma_n), .fc(fc), .bgack_n(bgack_n),
    .addr_hi(addr_hi), .data(data), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_data(rec_data), .rec_status(rec_status), .rec_addr_only(rec_addr_only)
  );

  // {addr[23:0], data[15:0], status[7:0]}; status: b0 rd_wr, b1 lds_n, b2 uds_n, b3 vma_n, b6..4 fc, b7 bgack_n
  localparam logic [47:0] VEC [6] = '{
    {24'h001234, 16'hBEEF, 8'h99},
    {24'hFFFFFF, 16'h1357, 8'hAA},
    {24'h000000, 16'hFFFF, 8'h55},
    {24'h5AA5A4, 16'h0000, 8'hFF},
    {24'hC0FFEE, 16'hA5C3, 8'h60},
    {24'h800001, 16'h7E81, 8'h8E}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_stat(logic [7:0] s, bit strobes);
    rd_wr = s[0]; vma_n = s[3]; fc = s[6:4]; bgack_n = s[7];
    lds_n = strobes ? s[1] : 1'b1;
    uds_n = strobes ? s[2] : 1'b1;
  endtask

  task automatic front_half(logic [47:0] v);
    @(negedge clk);
    cpu_clk = 0; as_n = 1; addr_hi = v[47:25]; data = ~v[23:8];
    set_stat(v[7:0], 0);
    waitn(H); cpu_clk = 1;
    waitn(H); cpu_clk = 0; as_n = 0; set_stat(v[7:0], 1);
    waitn(H); cpu_clk = 1;
    waitn(H);
  endtask

  task automatic check_record(string tag, logic [47:0] v);
    logic [23:0] ea;
    ea = {v[47:25], v[2]};
    waitn(2); chk({tag, " R1 early"}, rec_valid, 0);
    waitn(1); chk({tag, " R1 pulse"}, rec_valid, 1);
    chk({tag, " R3/R5 addr"}, rec_addr, ea);
    chk({tag, " R4 data"}, rec_data, v[23:8]);
    chk({tag, " R2 status"}, rec_status, v[7:0]);
    chk({tag, " R6 addr-only"}, rec_addr_only, v[1] & v[2]);
    waitn(1); chk({tag, " R1 single"}, rec_valid, 0);
    chk({tag, " R1 hold"}, rec_addr, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    as_n = 0;
    waitn(6);
    chk("R7 reset valid", rec_valid, 0);
    chk("R7 reset addr", rec_addr, 0);
    chk("R7 reset data", rec_data, 0);
    chk("R7 reset status", {rec_status, rec_addr_only}, 0);
    rst_n = 1;
    waitn(4); as_n = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 8; i++) begin waitn(1); if (rec_valid) seen = 1; end
      chk("R7 no record without fall", seen, 0);
    end

    for (int k = 0; k < 6; k++) begin
      front_half(VEC[k]);
      cpu_clk = 0; as_n = 1; uds_n = 1; lds_n = 1;
      data = VEC[k][23:8];
      addr_hi = ~VEC[k][47:25]; fc = ~VEC[k][6:4]; rd_wr = ~VEC[k][0];
      check_record($sformatf("vec%0d", k), VEC[k]);
      waitn(H);
    end

    // R3: CPU clock rise and strobe rise detected in the same system cycle
    begin
      logic [47:0] v = {24'h3C3C3C, 16'h5AA5, 8'h98};
      front_half(v);
      cpu_clk = 0;
      waitn(H);
      cpu_clk = 1; as_n = 1; uds_n = 1; lds_n = 1;
      addr_hi = 23'h7FFFFF; fc = 3'b111; data = v[23:8];
      check_record("collide R3", v);
      waitn(H);
    end

    // R8: CPU clock toggling with strobe idle
    begin
      bit seen = 0;
      for (int i = 0; i < 4; i++) begin
        cpu_clk = ~cpu_clk;
        for (int j = 0; j < H; j++) begin waitn(1); if (rec_valid) seen = 1; end
      end
      chk("R8 idle no record", seen, 0);
      chk("R8 idle hold addr", rec_addr, {23'h1E1E1E, 1'b0});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule